// File: doc/BRIEF.md
# Cell-Ordered Bitmap Line Plotter

This block draws a straight line into a one-bit-per-pixel bitmap whose bytes are laid out by character cell, not by scan line. Inside one cell row, eight consecutive bytes cover the same eight-pixel column on eight successive scan lines. Horizontally adjacent cells sit 8 bytes apart, and one cell row takes 320 bytes. A host places two endpoints on the inputs and pulses `start`. The engine then runs an integer error-accumulation line walk and sets each pixel with a read-modify-write OR on a simple synchronous byte memory port.

The pen position is held as a byte offset and a one-hot bit mask. The position is never recomputed from coordinates after the first pixel. Each move to a neighbouring pixel adjusts the offset and mask in place. Horizontal moves rotate the mask and add or remove 8 when the mask wraps. Vertical moves step the offset by one and add or remove a further 312 when they cross a cell-row boundary. The bitmap origin in memory comes from `base_addr`.

Top module: `cell_line_plotter`

## Requirements
- R1: A `start` pulse is accepted only while the engine is idle, meaning `busy` and `done` are both low. The endpoints are captured at that edge. `busy` is high for the whole pixel sequence. `start` pulses and endpoint changes during a run have no effect on it.
- R2: The first pixel is at (x0,y0). Its byte offset is 320*(y0>>3) + (y0&7) + (x0 with its low three bits cleared). Its mask is 8'h80 shifted right by (x0&7), so the leftmost pixel of a byte is bit 7.
- R3: A step right rotates the mask right by one and adds 8 to the offset when bit 0 wraps into bit 7. A step left rotates the mask left by one and subtracts 8 when bit 7 wraps into bit 0.
- R4: A step down adds 1 to the offset, then adds 312 more if the low three offset bits are then zero. A step up first subtracts 312 if the low three offset bits are zero, then subtracts 1.
- R5: Let |dx|=|x1-x0| and |dy|=|y1-y0|. The x axis is the major axis only when |dx| > |dy|; equal lengths make y the major axis. A difference of zero or more steps right or down, and a negative difference steps left or up.
- R6: The error starts at major-minor. After each pixel the engine steps the major axis and subtracts 2*minor. If the result is negative, it also steps the minor axis and adds 2*major.
- R7: A line sets exactly `major` pixels: the start pixel is included and the end pixel is excluded. A zero-length line writes nothing.
- R8: Each pixel is one read cycle followed by one write cycle to the same address, base_addr + offset. The written byte is the read byte ORed with the mask, so no existing bit is cleared.
- R9: `done` is a one-cycle pulse with `busy` low. It comes in the cycle after the last write, or in the cycle after `start` for a zero-length line. `done` therefore first appears 2*major+1 cycles after the accepting edge.
- R10: After reset the engine is idle, with `busy`, `done`, `mem_rd_en` and `mem_wr_en` all low. While it is not busy it issues no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a line (accepted when idle) |
| x0 | input | COORD_W | Start column |
| y0 | input | COORD_W | Start row |
| x1 | input | COORD_W | End column |
| y1 | input | COORD_W | End row |
| base_addr | input | ADDR_W | Memory address of bitmap byte 0 |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Byte address for read and write |
| mem_rd_en | output | 1 | Read request; data returns next cycle |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |

## Verification
Before every line the bench fills memory with random bytes, so a plot that clears neighbouring bits, or writes instead of ORing, leaves visible damage. Directed lines cross byte boundaries in both horizontal directions and cross cell rows in both vertical directions. An engine that skips the wrap adjustment or mis-orders the up-step test would scatter pixels into the wrong byte. Lines in all eight octants, an equal-length diagonal, a zero-length line and a single-pixel line check the axis choice, the tie rule and the pixel count; a wrong count shows up both as an extra endpoint pixel and as a mis-timed `done`. A second `start` with new endpoints is issued during a run: an engine that re-latches would draw a mixed image.

// File: rtl/cellplot_pkg.sv
package cellplot_pkg;

  localparam int PEN_OFS_W      = 32;
  localparam int PIX_PER_BYTE   = 8;
  localparam int CELL_ROW_BYTES = 320;
  localparam int CELL_ROW_SKIP  = CELL_ROW_BYTES - PIX_PER_BYTE;

  typedef enum logic [1:0] {
    DIR_RIGHT = 2'd0,
    DIR_LEFT  = 2'd1,
    DIR_DOWN  = 2'd2,
    DIR_UP    = 2'd3
  } step_dir_e;

  typedef struct packed {
    logic [PIX_PER_BYTE-1:0] mask;
    logic [PEN_OFS_W-1:0]    ofs;
  } pen_t;

  // Mask for the first pixel: bit 7 is the leftmost pixel of a byte.
  function automatic logic [PIX_PER_BYTE-1:0] first_mask(input logic [2:0] xlo);
    return 8'h80 >> xlo;
  endfunction

  // Byte offset of pixel (x,y) in the cell-ordered layout.
  function automatic logic [PEN_OFS_W-1:0] first_offset(input logic [PEN_OFS_W-1:0] x,
                                                       input logic [PEN_OFS_W-1:0] y);
    logic [PEN_OFS_W-1:0] cell_row;
    cell_row = y >> 3;
    return cell_row * PEN_OFS_W'(CELL_ROW_BYTES) + {29'd0, y[2:0]} + {x[PEN_OFS_W-1:3], 3'b000};
  endfunction

  function automatic pen_t step_pen(input pen_t p, input step_dir_e d);
    pen_t n;
    n = p;
    case (d)
      DIR_RIGHT: begin
        n.mask = {p.mask[0], p.mask[PIX_PER_BYTE-1:1]};
        if (p.mask[0]) n.ofs = p.ofs + PEN_OFS_W'(PIX_PER_BYTE);
      end
      DIR_LEFT: begin
        n.mask = {p.mask[PIX_PER_BYTE-2:0], p.mask[PIX_PER_BYTE-1]};
        if (p.mask[PIX_PER_BYTE-1]) n.ofs = p.ofs - PEN_OFS_W'(PIX_PER_BYTE);
      end
      DIR_DOWN: begin
        n.ofs = p.ofs + 1'b1;
        if (n.ofs[2:0] == 3'd0) n.ofs = n.ofs + PEN_OFS_W'(CELL_ROW_SKIP);
      end
      default: begin
        if (p.ofs[2:0] == 3'd0) n.ofs = p.ofs - PEN_OFS_W'(CELL_ROW_SKIP);
        n.ofs = n.ofs - 1'b1;
      end
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cp_setup.sv
module cp_setup
  import cellplot_pkg::*;
#(
  parameter int COORD_W = 16,
  localparam int ERR_W  = COORD_W + 3
) (
  input  logic [COORD_W-1:0]      x0,
  input  logic [COORD_W-1:0]      y0,
  input  logic [COORD_W-1:0]      x1,
  input  logic [COORD_W-1:0]      y1,
  output pen_t                    pen0,
  output step_dir_e               major_dir,
  output step_dir_e               minor_dir,
  output logic [COORD_W-1:0]      major_len,
  output logic [COORD_W-1:0]      minor_len,
  output logic signed [ERR_W-1:0] err0
);

  logic signed [COORD_W:0] dx_s, dy_s;
  logic [COORD_W-1:0]      adx, ady;
  logic                    x_is_major;
  step_dir_e               xdir, ydir;

  assign dx_s = $signed({1'b0, x1}) - $signed({1'b0, x0});
  assign dy_s = $signed({1'b0, y1}) - $signed({1'b0, y0});
  assign adx  = dx_s[COORD_W] ? COORD_W'(-dx_s) : dx_s[COORD_W-1:0];
  assign ady  = dy_s[COORD_W] ? COORD_W'(-dy_s) : dy_s[COORD_W-1:0];
  assign xdir = dx_s[COORD_W] ? DIR_LEFT : DIR_RIGHT;
  assign ydir = dy_s[COORD_W] ? DIR_UP   : DIR_DOWN;

  // Strict compare: equal lengths go to the vertical axis.
  assign x_is_major = adx > ady;
  assign major_len  = x_is_major ? adx  : ady;
  assign minor_len  = x_is_major ? ady  : adx;
  assign major_dir  = x_is_major ? xdir : ydir;
  assign minor_dir  = x_is_major ? ydir : xdir;

  assign err0 = $signed({3'b000, major_len}) - $signed({3'b000, minor_len});

  assign pen0.mask = first_mask(x0[2:0]);
  assign pen0.ofs  = first_offset(PEN_OFS_W'(x0), PEN_OFS_W'(y0));

endmodule

// File: rtl/cp_err.sv
module cp_err #(
  parameter int COORD_W = 16,
  localparam int ERR_W  = COORD_W + 3
) (
  input  logic signed [ERR_W-1:0] err_q,
  input  logic [COORD_W-1:0]      major_len,
  input  logic [COORD_W-1:0]      minor_len,
  output logic signed [ERR_W-1:0] err_d,
  output logic                    take_minor
);

  logic signed [ERR_W-1:0] twice_minor, twice_major, after_major;

  assign twice_minor = $signed({2'b00, minor_len, 1'b0});
  assign twice_major = $signed({2'b00, major_len, 1'b0});
  assign after_major = err_q - twice_minor;
  assign take_minor  = after_major < 0;
  assign err_d       = take_minor ? after_major + twice_major : after_major;

endmodule

// File: rtl/cp_stepper.sv
module cp_stepper
  import cellplot_pkg::*;
#(
  parameter int N_STAGES = 2
) (
  input  pen_t      pen_q,
  input  step_dir_e major_dir,
  input  step_dir_e minor_dir,
  input  logic      take_minor,
  output pen_t      pen_d
);

  pen_t      chain   [N_STAGES+1];
  step_dir_e dir_sel [N_STAGES];
  logic      en_sel  [N_STAGES];

  assign chain[0]   = pen_q;
  assign dir_sel[0] = major_dir;
  assign en_sel[0]  = 1'b1;
  assign dir_sel[1] = minor_dir;
  assign en_sel[1]  = take_minor;

  // Major step first, then the optional minor step on its result.
  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    assign chain[g+1] = en_sel[g] ? step_pen(chain[g], dir_sel[g]) : chain[g];
  end

  assign pen_d = chain[N_STAGES];

endmodule

// File: rtl/cell_line_plotter.sv
module cell_line_plotter
  import cellplot_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int ADDR_W  = 16,
  localparam int ERR_W  = COORD_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic [ADDR_W-1:0]  base_addr,
  output logic               busy,
  output logic               done,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd_en,
  input  logic [7:0]         mem_rdata,
  output logic               mem_wr_en,
  output logic [7:0]         mem_wdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FIN} phase_e;

  phase_e                  phase_q;
  pen_t                    pen_q, pen_d, pen0;
  step_dir_e               major_dir_q, minor_dir_q, major_dir0, minor_dir0;
  logic [COORD_W-1:0]      major_q, minor_q, major0, minor0, left_q;
  logic signed [ERR_W-1:0] err_q, err_d, err0;

  // Internal events brought out by name for the checker.
  logic       accept;
  logic       take_minor;
  logic       last_pixel;
  logic [7:0] plot_mask;

  cp_setup #(.COORD_W(COORD_W)) setup_i (
    .x0(x0), .y0(y0), .x1(x1), .y1(y1),
    .pen0(pen0), .major_dir(major_dir0), .minor_dir(minor_dir0),
    .major_len(major0), .minor_len(minor0), .err0(err0)
  );

  cp_err #(.COORD_W(COORD_W)) err_i (
    .err_q(err_q), .major_len(major_q), .minor_len(minor_q),
    .err_d(err_d), .take_minor(take_minor)
  );

  cp_stepper #(.N_STAGES(2)) step_i (
    .pen_q(pen_q), .major_dir(major_dir_q), .minor_dir(minor_dir_q),
    .take_minor(take_minor), .pen_d(pen_d)
  );

  assign accept     = (phase_q == ST_IDLE) && start;
  assign last_pixel = (left_q == COORD_W'(1));
  assign plot_mask  = pen_q.mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= ST_IDLE;
      pen_q       <= '0;
      major_dir_q <= DIR_RIGHT;
      minor_dir_q <= DIR_DOWN;
      major_q     <= '0;
      minor_q     <= '0;
      left_q      <= '0;
      err_q       <= '0;
    end else begin
      case (phase_q)
        ST_IDLE: if (accept) begin
          pen_q       <= pen0;
          major_dir_q <= major_dir0;
          minor_dir_q <= minor_dir0;
          major_q     <= major0;
          minor_q     <= minor0;
          left_q      <= major0;
          err_q       <= err0;
          phase_q     <= (major0 == '0) ? ST_FIN : ST_READ;
        end
        ST_READ:  phase_q <= ST_WRITE;
        ST_WRITE: begin
          pen_q   <= pen_d;
          err_q   <= err_d;
          left_q  <= left_q - 1'b1;
          phase_q <= last_pixel ? ST_FIN : ST_READ;
        end
        default:  phase_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (phase_q == ST_READ) || (phase_q == ST_WRITE);
  assign done      = (phase_q == ST_FIN);
  assign mem_rd_en = (phase_q == ST_READ);
  assign mem_wr_en = (phase_q == ST_WRITE);
  assign mem_addr  = base_addr + ADDR_W'(pen_q.ofs);
  assign mem_wdata = mem_rdata | pen_q.mask;

endmodule

// File: rtl/cell_line_plotter_chk.sv
module cell_line_plotter_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [7:0]        mem_rdata,
  input logic [7:0]        mem_wdata,
  input logic [7:0]        plot_mask
);

  p_accept_runs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy || done));

  p_mask_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(plot_mask) == 1));

  p_write_follows_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && $stable(mem_addr)));

  p_or_keeps_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (((mem_wdata & mem_rdata) == mem_rdata) &&
                   ($countones(mem_wdata ^ mem_rdata) <= 1)));

  p_rd_wr_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> $past(mem_wr_en));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !mem_wr_en));

endmodule

bind cell_line_plotter cell_line_plotter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .done(done),
  .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .plot_mask(plot_mask)
);

// File: tb/cell_line_plotter_tb_top.sv
module cell_line_plotter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int COORD_W    = 16;
  localparam int ADDR_W     = 16;
  localparam int MEM_AW     = 12;
  localparam int MEM_BYTES  = 1 << MEM_AW;
  localparam int BASE       = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [COORD_W-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
  logic [ADDR_W-1:0]  base_addr = ADDR_W'(BASE);
  logic busy, done, mem_rd_en, mem_wr_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] mem_wdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int wr_count = 0;
  logic [ADDR_W-1:0] last_wr_addr = '0;
  logic [7:0] last_wr_data = 8'h00;

  logic [7:0] mem     [MEM_BYTES];
  logic [7:0] exp_mem [MEM_BYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_line_plotter #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .x0(x0), .y0(y0), .x1(x1), .y1(y1),
    .base_addr(base_addr), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata)
  );

  // Synchronous byte memory: read data arrives the cycle after the request.
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[MEM_AW-1:0]];
    if (mem_wr_en) begin
      mem[mem_addr[MEM_AW-1:0]] = mem_wdata;
      wr_count     = wr_count + 1;
      last_wr_addr = mem_addr;
      last_wr_data = mem_wdata;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int ref_addr(input int x, input int y);
    return BASE + (y / 8) * 320 + (x / 8) * 8 + (y % 8);
  endfunction

  function automatic int ref_bit(input int x);
    return 7 - (x % 8);
  endfunction

  // Reference walk in plain coordinates; returns the number of pixels set.
  function automatic int ref_draw(input int ax, input int ay, input int bx, input int by);
    int dx, dy, adx, ady, sx, sy, maj, mnr, err, cx, cy;
    bit xmaj;
    dx = bx - ax; dy = by - ay;
    adx = (dx < 0) ? -dx : dx;
    ady = (dy < 0) ? -dy : dy;
    sx = (dx < 0) ? -1 : 1;
    sy = (dy < 0) ? -1 : 1;
    xmaj = adx > ady;
    maj = xmaj ? adx : ady;
    mnr = xmaj ? ady : adx;
    err = maj - mnr;
    cx = ax; cy = ay;
    for (int i = 0; i < maj; i++) begin
      exp_mem[ref_addr(cx, cy)][ref_bit(cx)] = 1'b1;
      if (xmaj) cx += sx; else cy += sy;
      err -= 2 * mnr;
      if (err < 0) begin
        if (xmaj) cy += sy; else cx += sx;
        err += 2 * maj;
      end
    end
    return maj;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i]     = 8'($urandom);
      exp_mem[i] = mem[i];
    end
  endtask

  task automatic compare_image(input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int i = 0; i < MEM_BYTES; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, req, "image", 0, 0);
    else check(1'b0, req, $sformatf("image byte %0d", first), mem[first], exp_mem[first]);
  endtask

  // Draw one line, with an optional interfering start during the run.
  task automatic run_line(input int ax, input int ay, input int bx, input int by,
                          input string req, input bit interfere);
    int maj, n, wr0;
    fill_random();
    maj = ref_draw(ax, ay, bx, by);
    wr0 = wr_count;
    @(negedge clk);
    x0 = COORD_W'(ax); y0 = COORD_W'(ay); x1 = COORD_W'(bx); y1 = COORD_W'(by);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (maj > 0)
      check(busy === 1'b1 && done === 1'b0, "R1", "busy after start", busy, 1);
    while (!done && n < 3000) begin
      if (interfere && n == 3) begin
        x0 = 5; y0 = 60; x1 = 250; y1 = 1; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(n == 2 * maj + 1, "R9", "cycles to done", n, 2 * maj + 1);
    check(wr_count - wr0 == maj, "R7", "write count", wr_count - wr0, maj);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R9", "done pulse width", done, 0);
    compare_image(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: idle after reset
    check(busy === 1'b0 && done === 1'b0 && mem_rd_en === 1'b0 && mem_wr_en === 1'b0,
          "R10", "reset outputs", {busy, done, mem_rd_en, mem_wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_rd_en === 1'b0 && mem_wr_en === 1'b0, "R10", "no access when idle",
          {mem_rd_en, mem_wr_en}, 0);

    // R2: single pixel at (13,9): offset 320+1+8 = 329, mask 8'h04
    run_line(13, 9, 14, 9, "R2", 1'b0);
    check(last_wr_addr == ADDR_W'(BASE + 329), "R2", "first address", last_wr_addr, BASE + 329);
    check(last_wr_data[2] == 1'b1, "R2", "first mask bit", last_wr_data, 8'h04);

    // R3: horizontal runs across byte boundaries, both directions
    run_line(3, 5, 30, 5, "R3", 1'b0);
    run_line(30, 5, 3, 5, "R3", 1'b0);
    // R4: vertical runs across cell rows, both directions
    run_line(10, 3, 10, 30, "R4", 1'b0);
    run_line(10, 30, 10, 3, "R4", 1'b0);
    // R5: equal lengths, zero-length
    run_line(0, 0, 40, 40, "R5", 1'b0);
    run_line(40, 40, 0, 0, "R5", 1'b0);
    run_line(50, 50, 50, 50, "R7", 1'b0);

    // R6: one line in each octant
    run_line(40, 10, 200, 50, "R6", 1'b0);
    run_line(200, 50, 40, 10, "R6", 1'b0);
    run_line(40, 50, 200, 10, "R6", 1'b0);
    run_line(200, 10, 40, 50, "R6", 1'b0);
    run_line(100, 2, 120, 60, "R6", 1'b0);
    run_line(120, 60, 100, 2, "R6", 1'b0);
    run_line(120, 2, 100, 60, "R6", 1'b0);
    run_line(100, 60, 120, 2, "R6", 1'b0);

    // R1: start and new endpoints during a run are ignored
    run_line(20, 20, 90, 33, "R1", 1'b1);

    // R8: random lines over random background
    for (int k = 0; k < 24; k++)
      run_line(int'($urandom_range(0, 255)), int'($urandom_range(0, 63)),
               int'($urandom_range(0, 255)), int'($urandom_range(0, 63)), "R8", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule